// File: doc/BRIEF.md
# Command Stream Packet Validator

This block sits between a command-word fetcher and a command queue. It takes a buffer of 32-bit command words and a buffer length in words. It decodes the header of each packet to learn how many words the packet spans, and forwards each legal packet to the output stream. The body words of a packet are passed through without inspection. After the last word of a packet, the block goes back to decoding the next header.

When a header cannot be decoded, the buffer is aborted. A header is undecodable when its class or opcode is unknown, or when its length comes out as zero. The buffer is also aborted when a packet would reach past the end of the buffer. On an abort, the offending header is not forwarded. Packets forwarded before the abort stay forwarded. The remaining input words are drained and discarded, and the block ends the buffer with a done pulse and a raised error flag.

When a buffer completes cleanly with an odd number of forwarded words, one zero word is appended so that the output total is even.

A buffer begins with a `start` pulse while the block is idle, which captures `buf_len`. Both streams use valid/ready handshakes. Input words are forwarded combinationally, so `in_ready` follows `out_ready` while a packet is being forwarded.

Top module: `cmd_pkt_validator`

## Requirements
- R1: Header bits [31:29] give the class. Classes 1, 4, 5, 6 and 7 are illegal. In class 0, bits [28:23] must be 0x00 or 0x04, and such a packet is one word long; any other class 0 value is illegal.
- R2: A class 2 packet is header bits [7:0] plus 2 words long.
- R3: In class 3, an opcode in bits [28:24] of at most 0x18, or equal to 0x1C, gives a one-word packet. Opcodes 0x19 to 0x1B are illegal.
- R4: Class 3 opcode 0x1D takes its length from a selector in bits [23:16]:
  - selector 3 gives bits [4:0] plus 2;
  - selector 4 gives bits [3:0] plus 2;
  - any other selector gives bits [15:0] plus 2.
- R5: Class 3 opcode 0x1E is bits [15:0] plus 1 words long when bit 23 is set, and one word long otherwise.
- R6: Class 3 opcode 0x1F has its length set as follows:
  - with bit 23 clear, the length is bits [16:0] plus 2;
  - with bits 23 and 17 both set, the length is ((bits [15:0] + 1) / 2) + 1, and the header is illegal when bits [15:0] are zero;
  - with bit 23 set and bit 17 clear, the length is 2.
- R7: An illegal header is not forwarded. Packets forwarded earlier are kept. All later words of the buffer are discarded, and the buffer ends with `done` and `err` high together.
- R8: A packet whose length exceeds the words left in the buffer, counting from its header, aborts the buffer as in R7. A packet that ends exactly on the last word is legal.
- R9: Body words are forwarded unchanged and are never decoded. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay unchanged, provided the input is held.
- R10: On a clean finish with an odd count of forwarded words, one 0x00000000 word is emitted before `done`. No pad word is emitted after an abort.
- R11: `done` is a one-cycle pulse. A buffer of length zero raises `done` with `err` low and forwards nothing.
- R12: Outside a buffer, `in_ready` and `out_valid` are low. A `start` pulse while a buffer is in progress is ignored.
- R13: Before `done` is raised, exactly `buf_len` input words have been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a buffer; sampled only when idle |
| buf_len | input | LEN_W | Buffer length in words, captured with start |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input command word |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output command word |
| out_ready | input | 1 | Downstream accepts the output word |
| done | output | 1 | One-cycle end-of-buffer pulse |
| err | output | 1 | Buffer was aborted; valid while done is high |

## Verification
Two events can fall in the same cycle. The first is the end of a packet coinciding with the end of the buffer, which must then decide on padding. The second is an abort on the very last word, where the error and the buffer end coincide.

The bench builds buffers so that a one-word header or the last body word lands exactly on the final word. Some of these buffers give an odd forwarded total and some give an even one. An undecodable header or an over-long packet is also placed in the last position.

A behavioural model built from queues predicts every output word, the pad word and the error flag. It is compared against each output handshake and each `done` pulse. The input consumed is checked to equal the buffer length. Valid gaps and back-pressure move these coincidences across different cycles.

// File: rtl/cpv_pkg.sv
package cpv_pkg;
   localparam int WORD_W = 32;
   // widest decoded packet length: 17-bit count plus 2
   localparam int PKT_W  = 18;

   typedef logic [PKT_W-1:0] plen_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_BODY,
      ST_DRAIN,
      ST_PAD,
      ST_FIN
   } cpv_state_e;
endpackage

// File: rtl/cpv_hdr_decode.sv
module cpv_hdr_decode
   import cpv_pkg::*;
(
   input  logic [WORD_W-1:0] hdr,
   output plen_t             len
);
   logic [2:0] cls;
   logic [4:0] op3;
   assign cls = hdr[31:29];
   assign op3 = hdr[28:24];

   always_comb begin
      len = '0;
      case (cls)
         3'd0: begin
            if (hdr[28:23] == 6'h00 || hdr[28:23] == 6'h04)
               len = plen_t'(1);
         end
         3'd2: len = plen_t'(hdr[7:0]) + plen_t'(2);
         3'd3: begin
            if (op3 <= 5'h18 || op3 == 5'h1C) begin
               len = plen_t'(1);
            end else begin
               case (op3)
                  5'h1D: begin
                     case (hdr[23:16])
                        8'h03:   len = plen_t'(hdr[4:0]) + plen_t'(2);
                        8'h04:   len = plen_t'(hdr[3:0]) + plen_t'(2);
                        default: len = plen_t'(hdr[15:0]) + plen_t'(2);
                     endcase
                  end
                  5'h1E: begin
                     if (hdr[23]) len = plen_t'(hdr[15:0]) + plen_t'(1);
                     else         len = plen_t'(1);
                  end
                  5'h1F: begin
                     if (!hdr[23])
                        len = plen_t'(hdr[16:0]) + plen_t'(2);
                     else if (hdr[17])
                        len = (hdr[15:0] == 16'h0) ? '0 :
                              ((plen_t'(hdr[15:0]) + plen_t'(1)) >> 1) + plen_t'(1);
                     else
                        len = plen_t'(2);
                  end
                  default: len = '0;
               endcase
            end
         end
         default: len = '0;
      endcase
   end
endmodule

// File: rtl/cpv_down_cnt.sv
module cpv_down_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic [W-1:0] cnt,
   output logic         at_one
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (load)  cnt <= load_val;
      else if (dec)   cnt <= cnt - W'(1);
   end

   assign at_one = (cnt == W'(1));
endmodule

// File: rtl/cmd_pkt_validator.sv
module cmd_pkt_validator
   import cpv_pkg::*;
#(
   parameter int LEN_W    = 16,
   parameter bit PAD_EVEN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LEN_W-1:0]  buf_len,
   input  logic              in_valid,
   input  logic [31:0]       in_data,
   output logic              in_ready,
   output logic              out_valid,
   output logic [31:0]       out_data,
   input  logic              out_ready,
   output logic              done,
   output logic              err
);
   localparam int CMP_W = (LEN_W > PKT_W) ? LEN_W : PKT_W;

   generate
      if (LEN_W < 1 || LEN_W > 31) begin : g_bad_len_w
         $error("cmd_pkt_validator: LEN_W must lie in 1..31");
      end
   endgenerate

   cpv_state_e st_q, st_d;
   logic       odd_q, err_q;
   logic       left_dec, body_load, body_dec, flip, set_err;
   logic       left_last, body_last, pad_need;
   logic [LEN_W-1:0] left_cnt;
   plen_t      body_cnt, hdr_len;
   logic       hdr_bad;

   cpv_hdr_decode u_dec (
      .hdr (in_data),
      .len (hdr_len)
   );

   cpv_down_cnt #(.W(LEN_W)) u_left (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (st_q == ST_IDLE && start),
      .load_val (buf_len),
      .dec      (left_dec),
      .cnt      (left_cnt),
      .at_one   (left_last)
   );

   cpv_down_cnt #(.W(PKT_W)) u_body (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (body_load),
      .load_val (hdr_len - plen_t'(1)),
      .dec      (body_dec),
      .cnt      (body_cnt),
      .at_one   (body_last)
   );

   assign hdr_bad = (hdr_len == '0) || (CMP_W'(hdr_len) > CMP_W'(left_cnt));

   // the word being forwarded flips parity; odd_q low means the total turns odd
   generate
      if (PAD_EVEN) begin : g_pad
         assign pad_need = !odd_q;
      end else begin : g_nopad
         assign pad_need = 1'b0;
      end
   endgenerate

   always_comb begin
      st_d      = st_q;
      in_ready  = 1'b0;
      out_valid = 1'b0;
      out_data  = in_data;
      left_dec  = 1'b0;
      body_load = 1'b0;
      body_dec  = 1'b0;
      flip      = 1'b0;
      set_err   = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (start) st_d = (buf_len == '0) ? ST_FIN : ST_HDR;
         end
         ST_HDR: begin
            if (in_valid) begin
               if (hdr_bad) begin
                  in_ready = 1'b1;
                  left_dec = 1'b1;
                  set_err  = 1'b1;
                  st_d     = left_last ? ST_FIN : ST_DRAIN;
               end else begin
                  out_valid = 1'b1;
                  in_ready  = out_ready;
                  if (out_ready) begin
                     left_dec = 1'b1;
                     flip     = 1'b1;
                     if (hdr_len == plen_t'(1)) begin
                        if (left_last) st_d = pad_need ? ST_PAD : ST_FIN;
                     end else begin
                        body_load = 1'b1;
                        st_d      = ST_BODY;
                     end
                  end
               end
            end
         end
         ST_BODY: begin
            out_valid = in_valid;
            in_ready  = out_ready;
            if (in_valid && out_ready) begin
               left_dec = 1'b1;
               body_dec = 1'b1;
               flip     = 1'b1;
               if (body_last) begin
                  if (left_last) st_d = pad_need ? ST_PAD : ST_FIN;
                  else           st_d = ST_HDR;
               end
            end
         end
         ST_DRAIN: begin
            in_ready = 1'b1;
            if (in_valid) begin
               left_dec = 1'b1;
               if (left_last) st_d = ST_FIN;
            end
         end
         ST_PAD: begin
            out_valid = 1'b1;
            out_data  = '0;
            if (out_ready) st_d = ST_FIN;
         end
         ST_FIN:  st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         odd_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_IDLE && start) begin
            odd_q <= 1'b0;
            err_q <= 1'b0;
         end else begin
            if (flip)    odd_q <= !odd_q;
            if (set_err) err_q <= 1'b1;
         end
      end
   end

   assign done = (st_q == ST_FIN);
   assign err  = (st_q == ST_FIN) && err_q;
endmodule

// File: rtl/cmd_pkt_validator_chk.sv
module cmd_pkt_validator_chk #(
   parameter int LEN_W    = 16,
   parameter bit PAD_EVEN = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [LEN_W-1:0] buf_len,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic [31:0]      out_data,
   input logic             out_ready,
   input logic             done,
   input logic             err
);
   logic             busy_c;
   logic [LEN_W-1:0] len_c;
   logic [31:0]      in_cnt, out_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_c  <= 1'b0;
         len_c   <= '0;
         in_cnt  <= '0;
         out_cnt <= '0;
      end else if (done) begin
         busy_c <= 1'b0;
      end else if (start && !busy_c) begin
         busy_c  <= 1'b1;
         len_c   <= buf_len;
         in_cnt  <= '0;
         out_cnt <= '0;
      end else begin
         if (in_valid && in_ready)   in_cnt  <= in_cnt + 32'd1;
         if (out_valid && out_ready) out_cnt <= out_cnt + 32'd1;
      end
   end

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_c |-> (!in_ready && !out_valid));

   p_consume_all_r13: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (in_cnt == 32'(len_c)));

   p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   generate
      if (PAD_EVEN) begin : g_even
         p_even_total_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (done && !err) |-> (out_cnt[0] == 1'b0));
      end
   endgenerate
endmodule

bind cmd_pkt_validator cmd_pkt_validator_chk #(.LEN_W(LEN_W), .PAD_EVEN(PAD_EVEN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .buf_len   (buf_len),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_data  (out_data),
   .out_ready (out_ready),
   .done      (done),
   .err       (err)
);

// File: tb/cmd_pkt_validator_test.sv
`timescale 1ns/1ps
module cmd_pkt_validator_test;
   localparam int CLK_PERIOD = 10;
   localparam int LEN_W      = 16;
   localparam int WDOG       = 150000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [LEN_W-1:0] buf_len = '0;
   logic             in_valid = 1'b0;
   logic [31:0]      in_data = '0;
   logic             in_ready, out_valid, out_ready, done, err;
   logic [31:0]      out_data;

   int vectors = 0;
   int fails   = 0;
   int cyc     = 0;

   logic [31:0] bq[$];
   logic [31:0] exp_q[$];
   bit          exp_err;

   cmd_pkt_validator #(.LEN_W(LEN_W), .PAD_EVEN(1'b1)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .buf_len   (buf_len),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .in_ready  (in_ready),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_ready (out_ready),
      .done      (done),
      .err       (err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > WDOG) begin
         fails = fails + 1;
         $display("FAIL watchdog: run hung, got cycle %0d expected below %0d", cyc, WDOG);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   // packet length from the requirement tables (R1..R6)
   function automatic int pkt_len(logic [31:0] h);
      int op;
      case (h[31:29])
         3'd0: return (h[28:23] == 6'h00 || h[28:23] == 6'h04) ? 1 : 0;
         3'd2: return int'(h[7:0]) + 2;
         3'd3: begin
            op = int'(h[28:24]);
            if (op <= 24 || op == 28) return 1;
            if (op == 29) begin
               if (h[23:16] == 8'd3) return int'(h[4:0]) + 2;
               if (h[23:16] == 8'd4) return int'(h[3:0]) + 2;
               return int'(h[15:0]) + 2;
            end
            if (op == 30) return h[23] ? int'(h[15:0]) + 1 : 1;
            if (op == 31) begin
               if (!h[23]) return int'(h[16:0]) + 2;
               if (h[17])  return (h[15:0] == 16'h0) ? 0 : (int'(h[15:0]) + 1) / 2 + 1;
               return 2;
            end
            return 0;
         end
         default: return 0;
      endcase
   endfunction

   task automatic build_model(input int len);
      int i = 0;
      int n = 0;
      exp_q.delete();
      exp_err = 1'b0;
      while (i < len) begin
         int sz = pkt_len(bq[i]);
         if (sz == 0 || i + sz > len) begin
            exp_err = 1'b1;
            break;
         end
         for (int k = 0; k < sz; k++) begin
            exp_q.push_back(bq[i + k]);
            n++;
         end
         i += sz;
      end
      if (!exp_err && (n % 2 == 1)) exp_q.push_back(32'h0);
   endtask

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] got, input logic [31:0] want);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, want);
      end
   endtask

   task automatic run_buf(input string tag, input int len, input bit poke);
      int  idx  = 0;
      bit  fin  = 1'b0;
      bit  hold = 1'b0;
      bit  fire;
      logic [31:0] e;
      build_model(len);
      @(posedge clk); #1;
      start   = 1'b1;
      buf_len = LEN_W'(len);
      @(posedge clk); #1;
      start   = 1'b0;
      while (!fin) begin
         if (!hold) in_valid = (idx < len) && ((cyc % 5) != 3);
         in_data   = (idx < len) ? bq[idx] : 32'hDEAD_BEEF;
         out_ready = ((cyc % 7) != 2);
         if (poke && idx == 2) begin
            start   = 1'b1;
            buf_len = LEN_W'(1);
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         fire = in_valid && in_ready;
         hold = in_valid && !in_ready;
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, tag, "unexpected output word", out_data, 32'h0);
            end else begin
               e = exp_q.pop_front();
               check(out_data === e, tag, "output word", out_data, e);
            end
         end
         if (done) begin
            check(err === exp_err, tag, "err at done", 32'(err), 32'(exp_err));
            check(exp_q.size() == 0, tag, "words still expected at done",
                  32'(exp_q.size()), 32'h0);
            check(idx == len, tag, "words consumed at done (R13)", 32'(idx), 32'(len));
            fin = 1'b1;
         end
         @(posedge clk); #1;
         if (fire) idx++;
      end
      start    = 1'b0;
      in_valid = 1'b0;
      @(negedge clk);
      check(!done, tag, "done pulse width (R11)", 32'(done), 32'h0);
      check(!in_ready && !out_valid, "R12", "idle handshake", {30'h0, in_ready, out_valid}, 32'h0);
   endtask

   initial begin
      out_ready = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(!in_ready && !out_valid && !done && !err, "R12", "reset outputs",
            {28'h0, in_ready, out_valid, done, err}, 32'h0);
      rst_n = 1'b1;

      // R1 legal class 0 operations, even total
      bq = '{32'h0000_0000, 32'h0200_0000};
      run_buf("R1", 2, 1'b0);

      // R2 class 2 length, R10 odd total padded
      bq = '{32'h4000_0001, 32'hAAAA_0001, 32'hAAAA_0002};
      run_buf("R2 R10", 3, 1'b0);

      // R3 R4 R5 R6 R9: class 3 opcode mix, bodies that look illegal
      bq = '{32'h7C00_0000,
             32'h6100_0000,
             32'h7D03_0001, 32'h2000_0000, 32'hFFFF_FFFF,
             32'h7D04_0012, 32'hB000_0001, 32'hB000_0002, 32'hB000_0003,
             32'h7D05_0001, 32'hA000_0000, 32'hB000_0004,
             32'h7E80_0002, 32'hB000_0005, 32'hB000_0006,
             32'h7E00_0005,
             32'h7F00_0001, 32'hB000_0007, 32'h7900_0000,
             32'h7F82_0003, 32'hB000_0008, 32'hB000_0009,
             32'h7F80_0000, 32'hE000_0000};
      run_buf("R3 R4 R5 R6 R9", 24, 1'b0);

      // R9 long body under back-pressure, ending on last word
      bq = {};
      bq.push_back(32'h7E80_000F);
      for (int k = 0; k < 15; k++) bq.push_back(32'hC0DE_0000 + k);
      bq.push_back(32'h7E00_0000);
      run_buf("R5 R9 R10", 17, 1'b0);

      // R7 illegal class 0 op after a good packet; no pad after abort
      bq = '{32'h0000_0000, 32'h0080_0000, 32'h0000_0000};
      run_buf("R1 R7 R10", 3, 1'b0);

      // R7 class 1 header first
      bq = '{32'h2000_0000, 32'h0000_0000};
      run_buf("R1 R7", 2, 1'b0);

      // R7 class 5 header on the only word
      bq = '{32'hA000_0000};
      run_buf("R1 R7", 1, 1'b0);

      // R3 opcode 0x19 illegal, abort on the last word
      bq = '{32'h0000_0000, 32'h7900_0000};
      run_buf("R3 R7", 2, 1'b0);

      // R6 zero count with bits 23 and 17 set
      bq = '{32'h7F82_0000, 32'h0000_0000, 32'h0000_0000};
      run_buf("R6 R7", 3, 1'b0);

      // R8 packet reaching past the end
      bq = '{32'h4000_0005, 32'h1, 32'h2, 32'h3};
      run_buf("R8", 4, 1'b0);

      // R8 packet ending exactly on the last word
      bq = '{32'h4000_0002, 32'h1, 32'h2, 32'h3};
      run_buf("R8", 4, 1'b0);

      // R11 zero-length buffer
      bq = {};
      run_buf("R11", 0, 1'b0);

      // R12 start during a buffer is ignored
      bq = '{32'h4000_0001, 32'h5, 32'h6, 32'h0000_0000, 32'h0200_0000};
      run_buf("R12", 5, 1'b1);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule